// File: doc/BRIEF.md
# Memory Parity Check and Error Reporting

This block sits beside a memory controller's data path and handles byte-lane parity. On the write side it produces one parity bit for each 8-bit lane of the write data. The sense of that bit, even or odd, comes from a polarity input. On the read side it computes the parity of each enabled lane again and compares it with the bit stored in memory. A mismatch raises a one-clock parity-error pulse, along with a mask of the lanes that failed.

What happens on an error depends on who owns the bus. When the on-chip master owns it, a fault can also raise an internal bus error, if the bus-error enable is set. When an external master owns it, only the parity-error pulse is raised, and only while the stored external-master timing mode permits parity. Of the four two-bit mode codes, only `11` permits parity for external cycles, and `10` is reserved. Loading `10` latches a sticky configuration error, and that error turns all checking off until reset.

Setting the bus-error enable inserts one register stage on the read data ahead of the compare. This gives the compare more room for its setup time, and it moves both error outputs one clock later.

Top module: `mem_parity_ctl`

## Requirements
- R1: For each lane i, `wr_par[i]` equals the XOR of the bits `wr_data[8i+7:8i]`, XORed with `cfg_odd`. So the lane's 8 data bits plus its parity bit hold an even count of ones when `cfg_odd`=0, and an odd count when `cfg_odd`=1. `wr_par` is combinational.
- R2: On a checked read, lane i is faulty when `rd_be[i]`=1 and the XOR of `rd_data[8i+7:8i]`, `rd_par[i]` and `cfg_odd` is 1. Lanes with `rd_be[i]`=0 are never faulty. `err_lanes` shows the faulty lanes while `perr` is high, and is 0 otherwise.
- R3: With `cfg_berr_en`=0, a read presented with `rd_valid`=1 at clock edge t drives `perr` high during the cycle after edge t when at least one lane is faulty. It is low in the following cycle unless another read faults.
- R4: A read with `ext_master`=0 while `cfg_berr_en`=1 raises `berr` in the same cycle as `perr` when it faults.
- R5: With `cfg_berr_en`=0, `berr` stays 0 whatever the read data.
- R6: A read with `ext_master`=1 never raises `berr`. It raises `perr` on a fault only while `par_active`=1.
- R7: The mode input `cfg_mode` (bit 1 = synchronous, bit 0 = fast timing) is stored at the clock edge where `cfg_mode_wr`=1. `par_active` is 1 exactly when the stored code is `11` and `cfg_err`=0. Codes `00` and `01` give 0, and the code after reset is `00`.
- R8: Loading code `10` sets `cfg_err`, which stays 1 until reset. While `cfg_err`=1 no read is checked, whichever master owns the bus, and a later load of `11` leaves `par_active` at 0.
- R9: With `cfg_berr_en`=1, `perr`, `berr` and `err_lanes` appear one cycle later than in R3: during the cycle after edge t+1. During the cycle after edge t they are 0.
- R10: Data written with `cfg_odd`=1 and read back with `cfg_odd`=0, with at least one lane enabled, gives a parity error on every enabled lane.
- R11: After reset, `perr`, `berr`, `err_lanes`, `cfg_err` and `par_active` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_odd | input | 1 | Parity sense: 0 even, 1 odd |
| cfg_berr_en | input | 1 | Parity faults raise the internal bus error (adds one read stage) |
| cfg_mode_wr | input | 1 | Load strobe for `cfg_mode` |
| cfg_mode | input | 2 | External-master timing mode code {synchronous, fast} |
| ext_master | input | 1 | 1 when an external master owns the read cycle |
| wr_data | input | 32 | Write data |
| wr_par | output | 4 | Generated parity, one bit per lane |
| rd_valid | input | 1 | Read data valid at this edge |
| rd_data | input | 32 | Read data from memory |
| rd_par | input | 4 | Stored parity bits from memory |
| rd_be | input | 4 | Lane enables of the read |
| perr | output | 1 | Registered parity-error pulse |
| berr | output | 1 | Registered internal bus-error pulse |
| err_lanes | output | 4 | Faulty lanes, valid with `perr` |
| par_active | output | 1 | Parity permitted for external-master reads |
| cfg_err | output | 1 | Sticky flag: reserved mode code was loaded |

## Verification
Several properties are checked on every cycle:
- the configuration error, once set, stays set, and its set condition holds;
- `par_active` is never high while the configuration error is set;
- `err_lanes` and `perr` agree;
- `berr` is never high without `perr`, without a previously set enable, or for an external master;
- a fully masked read, or an external read while parity is off, raises no error on the direct path.

Only the bench scenarios can show that the correct parity value is produced, because that needs data-derived expected values. The same holds for the exact latency on each path, the one-cycle pulse width, and the odd/even injection sequence.

// File: rtl/mpar_pkg.sv
package mpar_pkg;

    typedef enum logic [1:0] {
        XM_ASYNC = 2'b00,
        XM_FAST  = 2'b01,
        XM_RSVD  = 2'b10,
        XM_SYNC  = 2'b11
    } xm_mode_e;

endpackage

// File: rtl/mpar_gen.sv
module mpar_gen #(
    parameter int LANES  = 4,
    parameter int LANE_W = 8
) (
    input  logic [LANES*LANE_W-1:0] data,
    input  logic                    odd,
    output logic [LANES-1:0]        par
);

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign par[g] = (^data[g*LANE_W +: LANE_W]) ^ odd;
    end

endmodule

// File: rtl/mpar_mode.sv
module mpar_mode
    import mpar_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       mode_wr,
    input  logic [1:0] mode_in,
    output logic       par_active,
    output logic       cfg_err
);

    typedef struct packed {
        xm_mode_e mode;
        logic     err;
        logic     active;
    } mode_st_t;

    mode_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (mode_wr) begin
            st_d.mode = xm_mode_e'(mode_in);
            if (xm_mode_e'(mode_in) == XM_RSVD) begin
                st_d.err = 1'b1;
            end
        end
        st_d.active = (st_d.mode == XM_SYNC) && !st_d.err;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{mode: XM_ASYNC, err: 1'b0, active: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign par_active = st_q.active;
    assign cfg_err    = st_q.err;

endmodule

// File: rtl/mpar_check.sv
module mpar_check #(
    parameter int LANES  = 4,
    parameter int LANE_W = 8,
    localparam int DW    = LANES * LANE_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             odd,
    input  logic             berr_en,
    input  logic             par_active,
    input  logic             cfg_err,
    input  logic             rd_valid,
    input  logic [DW-1:0]    rd_data,
    input  logic [LANES-1:0] rd_par,
    input  logic [LANES-1:0] rd_be,
    input  logic             ext_master,
    output logic             perr,
    output logic             berr,
    output logic [LANES-1:0] err_lanes
);

    typedef struct packed {
        logic             s_valid;
        logic [DW-1:0]    s_data;
        logic [LANES-1:0] s_par;
        logic [LANES-1:0] s_be;
        logic             s_ext;
        logic             perr;
        logic             berr;
        logic [LANES-1:0] lanes;
    } chk_st_t;

    chk_st_t st_d, st_q;

    logic             src_valid;
    logic [DW-1:0]    src_data;
    logic [LANES-1:0] src_par;
    logic [LANES-1:0] src_be;
    logic             src_ext;
    logic [LANES-1:0] calc_par;
    logic [LANES-1:0] lane_bad;
    logic             checked;
    logic             fault;

    always_comb begin
        if (berr_en) begin
            src_valid = st_q.s_valid;
            src_data  = st_q.s_data;
            src_par   = st_q.s_par;
            src_be    = st_q.s_be;
            src_ext   = st_q.s_ext;
        end else begin
            src_valid = rd_valid;
            src_data  = rd_data;
            src_par   = rd_par;
            src_be    = rd_be;
            src_ext   = ext_master;
        end
    end

    mpar_gen #(.LANES(LANES), .LANE_W(LANE_W)) u_regen (
        .data (src_data),
        .odd  (odd),
        .par  (calc_par)
    );

    always_comb begin
        st_d         = st_q;
        st_d.s_valid = rd_valid;
        st_d.s_data  = rd_data;
        st_d.s_par   = rd_par;
        st_d.s_be    = rd_be;
        st_d.s_ext   = ext_master;

        lane_bad = (calc_par ^ src_par) & src_be;
        checked  = !cfg_err && (src_ext ? par_active : 1'b1);
        fault    = src_valid && checked && (|lane_bad);

        st_d.perr  = fault;
        st_d.berr  = fault && berr_en && !src_ext;
        st_d.lanes = fault ? lane_bad : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign perr      = st_q.perr;
    assign berr      = st_q.berr;
    assign err_lanes = st_q.lanes;

endmodule

// File: rtl/mem_parity_ctl.sv
module mem_parity_ctl #(
    parameter int LANES  = 4,
    parameter int LANE_W = 8,
    localparam int DW    = LANES * LANE_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_odd,
    input  logic             cfg_berr_en,
    input  logic             cfg_mode_wr,
    input  logic [1:0]       cfg_mode,
    input  logic             ext_master,
    input  logic [DW-1:0]    wr_data,
    output logic [LANES-1:0] wr_par,
    input  logic             rd_valid,
    input  logic [DW-1:0]    rd_data,
    input  logic [LANES-1:0] rd_par,
    input  logic [LANES-1:0] rd_be,
    output logic             perr,
    output logic             berr,
    output logic [LANES-1:0] err_lanes,
    output logic             par_active,
    output logic             cfg_err
);

    mpar_gen #(.LANES(LANES), .LANE_W(LANE_W)) u_wgen (
        .data (wr_data),
        .odd  (cfg_odd),
        .par  (wr_par)
    );

    mpar_mode u_mode (
        .clk        (clk),
        .rst_n      (rst_n),
        .mode_wr    (cfg_mode_wr),
        .mode_in    (cfg_mode),
        .par_active (par_active),
        .cfg_err    (cfg_err)
    );

    mpar_check #(.LANES(LANES), .LANE_W(LANE_W)) u_check (
        .clk        (clk),
        .rst_n      (rst_n),
        .odd        (cfg_odd),
        .berr_en    (cfg_berr_en),
        .par_active (par_active),
        .cfg_err    (cfg_err),
        .rd_valid   (rd_valid),
        .rd_data    (rd_data),
        .rd_par     (rd_par),
        .rd_be      (rd_be),
        .ext_master (ext_master),
        .perr       (perr),
        .berr       (berr),
        .err_lanes  (err_lanes)
    );

endmodule

// File: rtl/mem_parity_ctl_chk.sv
module mem_parity_ctl_chk #(
    parameter int LANES = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cfg_berr_en,
    input logic             cfg_mode_wr,
    input logic [1:0]       cfg_mode,
    input logic             ext_master,
    input logic             rd_valid,
    input logic [LANES-1:0] rd_be,
    input logic             perr,
    input logic             berr,
    input logic [LANES-1:0] err_lanes,
    input logic             par_active,
    input logic             cfg_err
);

    AST_CFGERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_err |=> cfg_err); // R8

    AST_CFGERR_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_mode_wr && cfg_mode == 2'b10) |=> cfg_err); // R8

    AST_ACTIVE_NOT_ERR: assert property (@(posedge clk) disable iff (!rst_n)
        par_active |-> !cfg_err); // R7

    AST_LANES_WITH_PERR: assert property (@(posedge clk) disable iff (!rst_n)
        (|err_lanes) == perr); // R2

    AST_BERR_NEEDS_PERR: assert property (@(posedge clk) disable iff (!rst_n)
        berr |-> perr); // R4

    AST_BERR_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_berr_en |=> !berr); // R5

    AST_EXT_NO_BERR: assert property (@(posedge clk) disable iff (!rst_n)
        berr |-> !$past(ext_master, 2)); // R6

    AST_EXT_OFF_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_berr_en && rd_valid && ext_master && !par_active) |=> !perr); // R6

    AST_MASKED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_berr_en && rd_valid && rd_be == '0) |=> !perr); // R2

endmodule

bind mem_parity_ctl mem_parity_ctl_chk #(.LANES(LANES)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cfg_berr_en (cfg_berr_en),
    .cfg_mode_wr (cfg_mode_wr),
    .cfg_mode    (cfg_mode),
    .ext_master  (ext_master),
    .rd_valid    (rd_valid),
    .rd_be       (rd_be),
    .perr        (perr),
    .berr        (berr),
    .err_lanes   (err_lanes),
    .par_active  (par_active),
    .cfg_err     (cfg_err)
);

// File: tb/mem_parity_ctl_tb.sv
`timescale 1ns/1ps
module mem_parity_ctl_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_odd = 1'b0;
    logic        cfg_berr_en = 1'b0;
    logic        cfg_mode_wr = 1'b0;
    logic [1:0]  cfg_mode = 2'b00;
    logic        ext_master = 1'b0;
    logic [31:0] wr_data = '0;
    logic [3:0]  wr_par;
    logic        rd_valid = 1'b0;
    logic [31:0] rd_data = '0;
    logic [3:0]  rd_par = '0;
    logic [3:0]  rd_be = '0;
    logic        perr, berr, par_active, cfg_err;
    logic [3:0]  err_lanes;

    int n_chk  = 0;
    int n_fail = 0;
    logic [1:0]  exp_mode = 2'b00;
    logic        exp_err  = 1'b0;
    logic [31:0] lfsr = 32'h1ACE_B00C;

    always #5 clk = ~clk;

    mem_parity_ctl u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_odd(cfg_odd), .cfg_berr_en(cfg_berr_en),
        .cfg_mode_wr(cfg_mode_wr), .cfg_mode(cfg_mode), .ext_master(ext_master),
        .wr_data(wr_data), .wr_par(wr_par), .rd_valid(rd_valid), .rd_data(rd_data),
        .rd_par(rd_par), .rd_be(rd_be), .perr(perr), .berr(berr),
        .err_lanes(err_lanes), .par_active(par_active), .cfg_err(cfg_err)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [3:0] exp_par(input logic [31:0] d, input logic odd);
        logic [3:0] p;
        for (int i = 0; i < 4; i++) begin
            p[i] = logic'($countones(d[8*i +: 8]) % 2) ^ odd;
        end
        return p;
    endfunction

    function automatic logic [31:0] next_lfsr(input logic [31:0] v);
        return {v[30:0], v[31] ^ v[21] ^ v[1] ^ v[0]};
    endfunction

    task automatic load_mode(input logic [1:0] m);
        @(negedge clk);
        cfg_mode = m;
        cfg_mode_wr = 1'b1;
        @(negedge clk);
        cfg_mode_wr = 1'b0;
        exp_mode = m;
        if (m == 2'b10) exp_err = 1'b1;
        chk("R7 par_active", par_active, (exp_mode == 2'b11) && !exp_err);
        chk("R8 cfg_err", cfg_err, exp_err);
    endtask

    task automatic do_read(input logic [31:0] d, input logic [3:0] p,
                           input logic [3:0] be, input logic ext);
        logic [3:0] bad;
        logic chkd, flt;
        string tag;
        bad  = be & (exp_par(d, cfg_odd) ^ p);
        chkd = !exp_err && (ext ? (exp_mode == 2'b11) : 1'b1);
        flt  = chkd && (bad != 0);
        tag  = ext ? "R6" : (cfg_berr_en ? "R4" : "R3");
        @(negedge clk);
        rd_valid = 1'b1; rd_data = d; rd_par = p; rd_be = be; ext_master = ext;
        @(negedge clk);
        rd_valid = 1'b0;
        if (cfg_berr_en) begin
            chk("R9 early perr", perr, 0);
            @(negedge clk);
        end
        chk({tag, " perr"}, perr, flt);
        chk(cfg_berr_en ? {tag, " berr"} : "R5 berr", berr, flt && cfg_berr_en && !ext);
        chk("R2 err_lanes", err_lanes, flt ? bad : 4'h0);
        @(negedge clk);
        chk("R3 pulse width", perr, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R11 perr", perr, 0);
        chk("R11 berr", berr, 0);
        chk("R11 err_lanes", err_lanes, 0);
        chk("R11 cfg_err", cfg_err, 0);
        chk("R11 par_active", par_active, 0);

        // R1: write parity over pseudo-random data, both senses
        for (int i = 0; i < 64; i++) begin
            for (int o = 0; o < 2; o++) begin
                @(negedge clk);
                wr_data = lfsr; cfg_odd = o[0];
                #1;
                chk("R1 wr_par", wr_par, exp_par(lfsr, o[0]));
            end
            lfsr = next_lfsr(lfsr);
        end

        // R7: legal codes
        load_mode(2'b00);
        load_mode(2'b01);
        load_mode(2'b11);

        // Sweep: bus-error enable, master, sense, lane enables, parity patterns
        for (int b = 0; b < 2; b++) begin
            for (int x = 0; x < 2; x++) begin
                for (int o = 0; o < 2; o++) begin
                    for (int be = 0; be < 16; be++) begin
                        for (int k = 0; k < 4; k++) begin
                            logic [3:0] pp;
                            cfg_berr_en = b[0];
                            cfg_odd = o[0];
                            pp = exp_par(lfsr, o[0]) ^ (k == 0 ? 4'h0 : k == 1 ? 4'hF :
                                                       k == 2 ? 4'h5 : 4'h8);
                            do_read(lfsr, pp, be[3:0], x[0]);
                            lfsr = next_lfsr(lfsr);
                        end
                    end
                end
            end
        end

        // R6: external reads with parity not permitted
        cfg_berr_en = 1'b0; cfg_odd = 1'b0;
        load_mode(2'b01);
        do_read(32'h0000_0001, 4'h0, 4'hF, 1'b1);
        cfg_berr_en = 1'b1;
        do_read(32'h0101_0101, 4'h0, 4'hF, 1'b1);
        load_mode(2'b00);
        do_read(32'h0000_0001, 4'h0, 4'hF, 1'b1);
        do_read(32'h0000_0001, 4'h0, 4'hF, 1'b0);

        // R10: write odd, read back even
        cfg_berr_en = 1'b0;
        @(negedge clk);
        cfg_odd = 1'b1; wr_data = 32'hA5C3_0F17;
        #1;
        begin
            logic [3:0] stored;
            stored = wr_par;
            cfg_odd = 1'b0;
            @(negedge clk);
            rd_valid = 1'b1; rd_data = 32'hA5C3_0F17; rd_par = stored;
            rd_be = 4'hB; ext_master = 1'b0;
            @(negedge clk);
            rd_valid = 1'b0;
            chk("R10 perr", perr, 1);
            chk("R10 err_lanes", err_lanes, 4'hB);
        end

        // R8: reserved code
        load_mode(2'b11);
        load_mode(2'b10);
        do_read(32'h0000_0001, 4'h0, 4'hF, 1'b0);
        do_read(32'h0000_0001, 4'h0, 4'hF, 1'b1);
        load_mode(2'b11);
        chk("R8 still off", par_active, 0);
        do_read(32'h0000_0003, 4'h1, 4'h1, 1'b0);

        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

endmodule